// File: doc/BRIEF.md
# Three-channel match timer

This block is a register-mapped timer unit for a system bus. It holds several independent up-counters. Each counter has a bank of match comparators, and each comparator has a sticky interrupt status bit and an enable bit. A counter runs in one of two modes. In periodic mode it restarts after its first comparator fires. In free-running mode it counts through every match and wraps. The counters run on a slow tick clock that is separate from the bus clock. Software enables and programs them through a plain valid/write/address/data slave port, and receives one interrupt line per timer.

The live count is never read straight across the clock boundary. Software writes a capture register to request a snapshot. The request crosses into the tick domain by a toggle handshake, the count is latched there, and the acknowledge crosses back. Software polls a valid flag and then reads the captured value. Until the handshake completes, the capture register keeps returning the previous snapshot. Software programs a match value as the wanted interval minus one. Intervals from 16 up to 0xFFFFFFFE ticks are intended.

Top module: `mtimer_unit`

## Requirements
- R1: After reset every register reads 0 and all `irq` bits are 0. The map uses word-aligned byte addresses. The enable register is at 0x00 and the mode register at 0x04, with bit n of each belonging to timer n. Timer n occupies the 32-byte window at 0x20*(n+1). Inside that window the offsets are: match k at 4*k (k=0..2), status at 0x0C, interrupt enable at 0x10, capture at 0x14, and capture state at 0x18.
- R2: Enable bit n = 1 makes timer n count. While the bit is 0 the count of timer n is held at 0, and after the bit is set again counting resumes from 0.
- R3: In free-running mode (mode bit 0) an enabled counter increases by one on every tick-clock edge. It counts straight through its match values and wraps modulo 2^32.
- R4: In periodic mode (mode bit 1), a match on comparator 0 makes the next count 0, so the counter never exceeds match 0. Matches on comparators 1 and 2 never change the count.
- R5: A counter equal to match k while enabled sets status bit k of that timer. The bit stays set until cleared. No status bit is set without a match.
- R6: Writing the status register clears each status bit whose written bit is 1. Bits written 0 are unchanged. A match arriving in the same bus cycle as its clear leaves the bit set.
- R7: `irq[n]` is 1 exactly when some status bit of timer n has its interrupt-enable bit set.
- R8: Writing a value with bit 0 = 1 to the capture register starts a snapshot. Capture-state bit 1 (pending) reads 1 and bit 0 (valid) reads 0 until the handshake completes. During that time the capture register still returns the previous snapshot. Afterwards bit 0 reads 1, bit 1 reads 0, and the capture register returns the count latched in the tick domain.
- R9: A capture write while a snapshot is pending is ignored. A capture write with bit 0 = 0 starts nothing and leaves the capture registers unchanged.
- R10: Timers are independent. The enable, mode, match, status and capture activity of one timer never changes another timer's count, status or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the register slave, status and capture results |
| tick_clk | input | 1 | Slow timer clock that the counters run on |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| req_valid | input | 1 | Bus access strobe, one bus cycle per write |
| req_write | input | 1 | 1 = write access when `req_valid` is high |
| req_addr | input | 8 | Byte address; the read data follows it combinationally |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the register at `req_addr` |
| irq | output | 3 | Per-timer interrupt, OR of enabled status bits |

## Verification
A counter that fails to reload, or that reloads on the wrong comparator, shows up in the next snapshot as a value above match 0, or capped at match 1, a few tick periods after the event. A counter that does not return to zero on disable shows up in the first capture taken after a stop or a restart. A broken request or acknowledge toggle leaves capture state stuck at pending, so the poll times out within a few hundred bus cycles. Wrong status set or clear logic appears on the status read and on `irq` in the bus cycle after the write.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int DATA_W     = 32;
  localparam int SLOT_SHIFT = 5;   // 32-byte register window per timer
  localparam int WORD_W     = SLOT_SHIFT - 2;

  // word offsets inside a timer window, derived from the comparator count
  function automatic int word_status(input int ncmp);
    return ncmp;
  endfunction
  function automatic int word_ien(input int ncmp);
    return ncmp + 1;
  endfunction
  function automatic int word_capture(input int ncmp);
    return ncmp + 2;
  endfunction
  function automatic int word_capstate(input int ncmp);
    return ncmp + 3;
  endfunction
endpackage

// File: rtl/mtimer_sync2.sv
module mtimer_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            tick_clk,
  input  logic                            rst_n,
  input  logic                            en_async,
  input  logic                            periodic,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   match,
  input  logic                            req_tgl_async,
  output logic                            ack_tgl,
  output logic [CNT_W-1:0]                snap,
  output logic [NUM_CMP-1:0]              hit_tgl,
  output logic [CNT_W-1:0]                count,
  output logic                            en_s,
  output logic [NUM_CMP-1:0]              hit
);
  logic req_s, req_seen;
  logic req_edge;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic reload);
    return reload ? '0 : cur + CNT_W'(1);
  endfunction

  mtimer_sync2 #(.W(1)) u_en_sync (
    .clk(tick_clk), .rst_n(rst_n), .d(en_async), .q(en_s)
  );
  mtimer_sync2 #(.W(1)) u_req_sync (
    .clk(tick_clk), .rst_n(rst_n), .d(req_tgl_async), .q(req_s)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign hit[k] = en_s && (count == match[k]);
  end

  assign req_edge = req_s ^ req_seen;

  always_ff @(posedge tick_clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!en_s) begin
      count <= '0;
    end else begin
      count <= step_count(count, periodic && hit[0]);
    end
  end

  always_ff @(posedge tick_clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_tgl <= '0;
    end else begin
      hit_tgl <= hit_tgl ^ hit;
    end
  end

  always_ff @(posedge tick_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      snap     <= '0;
    end else if (req_edge) begin
      req_seen <= req_s;
      ack_tgl  <= ~ack_tgl;
      snap     <= count;
    end
  end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtimer_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_CMP    = 3,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                  bus_clk,
  input  logic                  tick_clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;
  localparam int W_STAT = word_status(NUM_CMP);
  localparam int W_IEN  = word_ien(NUM_CMP);
  localparam int W_CAPT = word_capture(NUM_CMP);
  localparam int W_CST  = word_capstate(NUM_CMP);

  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_glb;
  logic [NUM_TIMERS-1:0] en_q, mode_q;

  // named internal events for the checker
  logic [NUM_TIMERS-1:0][NUM_CMP-1:0] stat_all, clr_all, set_all;
  logic [NUM_TIMERS-1:0]              pend_all, valid_all, ens_all, hit0_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]   cnt_all;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]  slot_rd;

  assign slot    = req_addr[ADDR_W-1:SLOT_SHIFT];
  assign word    = req_addr[SLOT_SHIFT-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign wr_glb  = req_valid && req_write && aligned && (slot == '0);

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (wr_glb) begin
      if (word == WORD_W'(0)) en_q   <= req_wdata[NUM_TIMERS-1:0];
      if (word == WORD_W'(1)) mode_q <= req_wdata[NUM_TIMERS-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [NUM_CMP-1:0][CNT_W-1:0] match_q;
    logic [NUM_CMP-1:0] ien_q, stat_q, clr_w, set_w;
    logic [NUM_CMP-1:0] hit_tgl, hit_s, hit_d, hit_now;
    logic               cap_tgl_q, pend_q, valid_q;
    logic [CNT_W-1:0]   cap_q, snap, count;
    logic               ack_tgl, ack_s, ack_d, ack_ev;
    logic               en_s;
    logic               sel, cap_go;
    logic [DATA_W-1:0]  rd;

    assign sel    = req_valid && req_write && aligned && (slot == SLOT_W'(t + 1));
    assign clr_w  = (sel && word == WORD_W'(W_STAT)) ? req_wdata[NUM_CMP-1:0] : '0;
    assign cap_go = sel && (word == WORD_W'(W_CAPT)) && req_wdata[0] && !pend_q;

    mtimer_core #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_core (
      .tick_clk      (tick_clk),
      .rst_n         (rst_n),
      .en_async      (en_q[t]),
      .periodic      (mode_q[t]),
      .match         (match_q),
      .req_tgl_async (cap_tgl_q),
      .ack_tgl       (ack_tgl),
      .snap          (snap),
      .hit_tgl       (hit_tgl),
      .count         (count),
      .en_s          (en_s),
      .hit           (hit_now)
    );

    mtimer_sync2 #(.W(NUM_CMP)) u_hit_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(hit_tgl), .q(hit_s)
    );
    mtimer_sync2 #(.W(1)) u_ack_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
    );

    assign set_w  = hit_s ^ hit_d;
    assign ack_ev = ack_s ^ ack_d;

    always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
        match_q <= '0;
        ien_q   <= '0;
      end else if (sel) begin
        for (int k = 0; k < NUM_CMP; k++) begin
          if (word == WORD_W'(k)) match_q[k] <= req_wdata[CNT_W-1:0];
        end
        if (word == WORD_W'(W_IEN)) ien_q <= req_wdata[NUM_CMP-1:0];
      end
    end

    // a new match outranks a clear in the same cycle
    always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_d  <= '0;
        stat_q <= '0;
      end else begin
        hit_d  <= hit_s;
        stat_q <= (stat_q & ~clr_w) | set_w;
      end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
        ack_d     <= 1'b0;
        cap_tgl_q <= 1'b0;
        pend_q    <= 1'b0;
        valid_q   <= 1'b0;
        cap_q     <= '0;
      end else begin
        ack_d <= ack_s;
        if (cap_go) begin
          cap_tgl_q <= ~cap_tgl_q;
          pend_q    <= 1'b1;
          valid_q   <= 1'b0;
        end else if (ack_ev) begin
          pend_q  <= 1'b0;
          valid_q <= 1'b1;
          cap_q   <= snap;
        end
      end
    end

    always_comb begin
      rd = '0;
      for (int k = 0; k < NUM_CMP; k++) begin
        if (word == WORD_W'(k)) rd[CNT_W-1:0] = match_q[k];
      end
      if (word == WORD_W'(W_STAT)) rd[NUM_CMP-1:0] = stat_q;
      if (word == WORD_W'(W_IEN))  rd[NUM_CMP-1:0] = ien_q;
      if (word == WORD_W'(W_CAPT)) rd[CNT_W-1:0]   = cap_q;
      if (word == WORD_W'(W_CST))  rd[1:0]         = {pend_q, valid_q};
    end

    assign slot_rd[t]   = rd;
    assign irq[t]       = |(stat_q & ien_q);
    assign stat_all[t]  = stat_q;
    assign clr_all[t]   = clr_w;
    assign set_all[t]   = set_w;
    assign pend_all[t]  = pend_q;
    assign valid_all[t] = valid_q;
    assign cnt_all[t]   = count;
    assign ens_all[t]   = en_s;
    assign hit0_all[t]  = hit_now[0];
  end

  always_comb begin
    rsp_rdata = '0;
    if (aligned) begin
      if (slot == '0) begin
        if (word == WORD_W'(0)) rsp_rdata[NUM_TIMERS-1:0] = en_q;
        if (word == WORD_W'(1)) rsp_rdata[NUM_TIMERS-1:0] = mode_q;
      end
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (slot == SLOT_W'(t + 1)) rsp_rdata = slot_rd[t];
      end
    end
  end
endmodule

// File: rtl/mtimer_checks.sv
module mtimer_checks #(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_CMP    = 3,
  parameter int CNT_W      = 32
) (
  input logic                               bus_clk,
  input logic                               tick_clk,
  input logic                               rst_n,
  input logic [NUM_TIMERS-1:0][NUM_CMP-1:0] stat_all,
  input logic [NUM_TIMERS-1:0][NUM_CMP-1:0] clr_all,
  input logic [NUM_TIMERS-1:0][NUM_CMP-1:0] set_all,
  input logic [NUM_TIMERS-1:0]              pend_all,
  input logic [NUM_TIMERS-1:0]              valid_all,
  input logic [NUM_TIMERS-1:0]              ens_all,
  input logic [NUM_TIMERS-1:0]              hit0_all,
  input logic [NUM_TIMERS-1:0]              mode_q,
  input logic [NUM_TIMERS-1:0][CNT_W-1:0]   cnt_all
);
  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_t
    assert_stop_zero_R2: assert property (@(posedge tick_clk) disable iff (!rst_n)
      !ens_all[t] |=> (cnt_all[t] == '0))
      else $error("R2 timer %0d count not held at zero", t);

    assert_count_step_R3: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (ens_all[t] && !(mode_q[t] && hit0_all[t])) |=> (cnt_all[t] == $past(cnt_all[t]) + CNT_W'(1)))
      else $error("R3 timer %0d count did not step", t);

    assert_reload_R4: assert property (@(posedge tick_clk) disable iff (!rst_n)
      (ens_all[t] && mode_q[t] && hit0_all[t]) |=> (cnt_all[t] == '0))
      else $error("R4 timer %0d periodic reload missing", t);

    assert_capture_completes_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
      pend_all[t] |=> (pend_all[t] || valid_all[t]))
      else $error("R8 timer %0d pending dropped without result", t);

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_k
      assert_match_sets_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        set_all[t][k] |=> stat_all[t][k])
        else $error("R5/R6 timer %0d status %0d not set by match", t, k);

      assert_no_spurious_R5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!stat_all[t][k] && !set_all[t][k]) |=> !stat_all[t][k])
        else $error("R5 timer %0d status %0d set without match", t, k);

      assert_sticky_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (stat_all[t][k] && !clr_all[t][k]) |=> stat_all[t][k])
        else $error("R6 timer %0d status %0d lost", t, k);

      assert_clear_R6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (clr_all[t][k] && !set_all[t][k]) |=> !stat_all[t][k])
        else $error("R6 timer %0d status %0d not cleared", t, k);
    end
  end
endmodule

bind mtimer_unit mtimer_checks #(
  .NUM_TIMERS(NUM_TIMERS), .NUM_CMP(NUM_CMP), .CNT_W(CNT_W)
) u_checks (
  .bus_clk   (bus_clk),
  .tick_clk  (tick_clk),
  .rst_n     (rst_n),
  .stat_all  (stat_all),
  .clr_all   (clr_all),
  .set_all   (set_all),
  .pend_all  (pend_all),
  .valid_all (valid_all),
  .ens_all   (ens_all),
  .hit0_all  (hit0_all),
  .mode_q    (mode_q),
  .cnt_all   (cnt_all)
);

// File: tb/test_mtimer_unit.sv
module test_mtimer_unit;
  localparam int W_M0 = 0, W_M1 = 1, W_M2 = 2, W_ST = 3, W_IE = 4, W_CP = 5, W_CS = 6;
  localparam logic [31:0] FAR = 32'hFFFF_FFF0;

  logic        bus_clk = 1'b0, tick_clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [2:0]  irq;
  int n_chk = 0, n_err = 0;

  always #10 bus_clk  = ~bus_clk;    // 50 MHz
  always #70 tick_clk = ~tick_clk;   // tick clock, 7 bus periods

  mtimer_unit i_mtimer_unit (
    .bus_clk(bus_clk), .tick_clk(tick_clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [7:0] ra(input int t, input int w);
    return 8'((t + 1) * 32 + w * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [31:0] act, input int lo, input int hi);
    n_chk++;
    if (act < 32'(lo) || act > 32'(hi)) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge bus_clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    req_addr = a;
    #2 d = rsp_rdata;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 7) @(posedge bus_clk);
  endtask

  task automatic capture(input int t, output logic [31:0] v);
    logic [31:0] s;
    int n;
    wr(ra(t, W_CP), 32'h1);
    s = '0; n = 0;
    while (s[0] !== 1'b1 && n < 400) begin
      rd(ra(t, W_CS), s);
      n++;
    end
    chk("R8 capture handshake completes", s, 32'h1);
    rd(ra(t, W_CP), v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v);          chk("R1 enable reset", v, 0);
    rd(8'h04, v);          chk("R1 mode reset", v, 0);
    rd(ra(0, W_M0), v);    chk("R1 match reset", v, 0);
    rd(ra(2, W_ST), v);    chk("R1 status reset", v, 0);
    rd(ra(1, W_IE), v);    chk("R1 ien reset", v, 0);
    rd(ra(0, W_CP), v);    chk("R1 capture reset", v, 0);
    rd(ra(0, W_CS), v);    chk("R1 capture state reset", v, 0);
    chk("R1 irq reset", 32'(irq), 0);
  endtask

  task automatic t_stopped;
    logic [31:0] v;
    capture(0, v);
    chk("R2 stopped timer captures zero", v, 0);
  endtask

  task automatic t_free_run;
    logic [31:0] a, b, c, v;
    for (int k = 0; k < 3; k++) wr(ra(1, k), FAR);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h2);
    wait_ticks(20);
    capture(1, a);
    chk_rng("R3 free-run count after 20 ticks", a, 14, 30);
    wait_ticks(10);
    capture(1, b);
    chk_rng("R3 free-run increment", b - a, 10, 20);
    rd(ra(1, W_ST), v);  chk("R5 no status without match", v, 0);
    capture(0, v);       chk("R10 disabled neighbour stays zero", v, 0);
    // second request: previous value held while pending
    wr(ra(1, W_CP), 32'h1);
    rd(ra(1, W_CS), v);  chk("R8 pending state", v, 32'h2);
    rd(ra(1, W_CP), v);  chk("R8 previous snapshot held", v, b);
    wr(ra(1, W_CP), 32'h1);   // ignored while pending (R9)
    v = '0;
    for (int n = 0; n < 400 && v[0] !== 1'b1; n++) rd(ra(1, W_CS), v);
    chk("R9 single handshake after repeated request", v, 32'h1);
    rd(ra(1, W_CP), c);
    chk_rng("R8 new snapshot advances", c - b, 1, 12);
    wr(ra(1, W_CP), 32'h0);
    wait_ticks(10);
    rd(ra(1, W_CS), v);  chk("R9 write of zero starts nothing", v, 32'h1);
    rd(ra(1, W_CP), v);  chk("R9 capture value kept", v, c);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wait_ticks(4);
    capture(1, v);       chk("R2 disabled count is zero", v, 0);
    wr(8'h00, 32'h2);
    capture(1, v);       chk_rng("R2 restart from zero", v, 0, 6);
  endtask

  task automatic t_periodic;
    logic [31:0] v, mx;
    wr(8'h00, 32'h0);
    wait_ticks(4);
    wr(8'h04, 32'h1);
    rd(8'h04, v);        chk("R1 mode readback", v, 32'h1);
    wr(ra(0, W_M0), 32'd19);
    wr(ra(0, W_M1), 32'd5);
    wr(ra(0, W_M2), FAR);
    wr(8'h00, 32'h3);
    mx = 0;
    for (int i = 0; i < 6; i++) begin
      wait_ticks(7);
      capture(0, v);
      chk_rng("R4 periodic count bounded by match 0", v, 0, 19);
      if (v > mx) mx = v;
    end
    chk_rng("R4 comparator 1 does not reload", mx, 6, 19);
    rd(ra(0, W_ST), v);  chk("R5 status bits 0 and 1 set", v, 32'h3);
    @(negedge bus_clk); #2 chk("R7 irq masked when ien clear", 32'(irq[0]), 0);
    wr(ra(0, W_IE), 32'h1);
    @(negedge bus_clk); #2 chk("R7 irq raised by enabled status", 32'(irq[0]), 1);
    chk("R10 other timer irq quiet", 32'(irq[2]), 0);
    // free-running timer counts through its match
    wr(8'h00, 32'h1);
    wait_ticks(4);
    wr(ra(1, W_M0), 32'd10);
    wr(8'h00, 32'h3);
    wait_ticks(30);
    capture(1, v);       chk_rng("R3 free-run passes match", v, 22, 42);
    rd(ra(1, W_ST), v);  chk("R5 free-run match status", v, 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wait_ticks(6);
    rd(ra(0, W_ST), v);  chk("R5 status sticky after stop", v, 32'h3);
    wr(ra(0, W_ST), 32'h0);
    rd(ra(0, W_ST), v);  chk("R6 zero write keeps bits", v, 32'h3);
    wr(ra(0, W_ST), 32'h2);
    rd(ra(0, W_ST), v);  chk("R6 clear bit 1 only", v, 32'h1);
    chk("R7 irq held by enabled bit 0", 32'(irq[0]), 1);
    wr(ra(0, W_ST), 32'h1);
    rd(ra(0, W_ST), v);  chk("R6 clear bit 0", v, 32'h0);
    chk("R7 irq drops after clear", 32'(irq[0]), 0);
    chk("R7 irq stays low without ien", 32'(irq[1]), 0);
    rd(ra(1, W_ST), v);  chk("R10 neighbour status untouched", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge tick_clk);
    @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (2) @(posedge bus_clk);
    t_reset();
    t_stopped();
    t_free_run();
    t_disable();
    t_periodic();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (R8 handshake or any requirement): actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule